// File: doc/BRIEF.md
# Super I/O Configuration Register Space

This block is the configuration space that a host sees for a legacy Super I/O. The host reaches it through a byte-wide I/O bus that has two ports. The index port (bus address 0) selects a register. The data port (bus address 1) reads or writes the selected register. The space is locked after reset. The host opens it by writing the key byte 0xA5 to the index port twice in a row, and closes it again by writing 0xAA. The space has no identification register, so every location that is locked or not implemented reads as 0xFF.

Indices below 0x30 are global. Index 0x07 holds the logical device number (LDN). Indices 0x20 to 0x2F form a zero-initialised scratch area. Indices 0x30 and above reach the register bank of the device that the LDN currently selects. Each bank holds an activate bit, a 16-bit base address, an interrupt number and an interrupt type. The keyboard-controller bank also holds a secondary base, a second interrupt pair and a mode byte.

The block drives no device logic of its own. It presents each device's activate bit, base address and interrupt number to the downstream decoders.

Top module: `sio_cfg_space`

## Requirements
- R1: After reset, and at any time while the space is locked, a read of either port returns 0xFF. All dev_active bits are 0 after reset.
- R2: The space opens only after two consecutive index-port writes of 0xA5. After a single 0xA5, data reads still return 0xFF.
- R3: An index-port write of any other value between the two key bytes cancels the sequence. The sequence 0xA5, 0x12, 0xA5 leaves the space locked.
- R4: While the space is open, an index-port write of 0xAA locks it. That write does not change the stored index.
- R5: Data-port writes made while the space is locked change no register and no output.
- R6: Index 0x20 always reads 0x00 and ignores writes. Indices 0x21 to 0x2F reset to 0x00 and read back the last value written to them.
- R7: Index 0x07 stores and reads back the LDN. Reads and writes at index 0x30 or above reach only the bank whose LDN equals that value.
- R8: Bank defaults, given as (index 0x60 high byte, 0x61 low byte, 0x70 IRQ, 0x71 type, 0x30 = 0x00):
  - LDN 0x02: 0x03F8, 4, 0x02
  - LDN 0x03: 0x02F8, 3, 0x02
  - LDN 0x0B: 0x03E8, 6, 0x02
  - LDN 0x0C: 0x02E8, 5, 0x02
  - LDN 0x0E: 0x08C0, 9, 0x01
  - LDN 0x07: 0x0000, 0x0B, 0x01
- R9: The keyboard-controller bank (LDN 0x05) resets as follows: base 0x0060, IRQ 1, type 0x02, 0x62/0x63 = 0x00/0x64, 0x72 = 0x0C, 0x73 = 0x02 and 0xF0 = 0x83.
- R10: Reads of the following return 0xFF, and writes to them change nothing: unimplemented global indices, bank indices that the selected device lacks, and any index at 0x30 or above when the LDN matches no device.
- R11: dev_active, dev_base and dev_irq (low 4 bits of index 0x70) follow each bank's registers in the cycle after a write. The slot order is 0:LDN2, 1:LDN3, 2:LDN5, 3:LDN7, 4:LDN0B, 5:LDN0C, 6:LDN0E.
- R12: While the space is open, a read of the index port returns the stored index.
- R13: When read and write strobes to the data port fall in the same cycle, the read returns the value held before that write. The new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 1 | 0 = index port, 1 = data port |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle bus_rd is high; 0xFF otherwise |
| dev_active | output | NDEV | Activate bit of each device slot |
| dev_base | output | NDEV*16 | Base address of each slot, slot i at bits [16i+15:16i] |
| dev_irq | output | NDEV*IRQ_W | Interrupt number of each slot, slot i at bits [IRQ_W*i+IRQ_W-1:IRQ_W*i] |

## Verification
A data-port read and a data-port write can share one cycle, because the bus has separate strobes and read data is combinational from the stored registers. The bench raises both strobes on the data port at scratch index 0x21. It expects the old byte in that cycle and the new byte on a plain read one cycle later. The relock key can also arrive while a decoder output is being observed. The bench therefore confirms that a data write issued right after 0xAA leaves both the register contents and the outputs untouched.

// File: rtl/sio_cfg_pkg.sv
`timescale 1ns/1ps
// Package sio_cfg_pkg
// Shared constants, key codes and per-slot reset data for the configuration space.
// Assumes that the device slots are numbered 0..NDEV-1 and that each slot's LDN is unique.
package sio_cfg_pkg;

    localparam logic [7:0] KEY_ENTER   = 8'hA5;
    localparam logic [7:0] KEY_EXIT    = 8'hAA;
    localparam logic [7:0] IDX_LDN     = 8'h07;
    localparam logic [7:0] IDX_GLB_LO  = 8'h20;
    localparam logic [7:0] IDX_BANK_LO = 8'h30;
    localparam logic [7:0] RD_IDLE     = 8'hFF;
    localparam int         NDEV        = 7;
    localparam int         GLB_N       = 16;

    // Fixed extra defaults of the keyboard-controller bank
    localparam logic [15:0] KBC_BASE2 = 16'h0064;
    localparam logic [7:0]  KBC_IRQ2  = 8'h0C;
    localparam logic [7:0]  KBC_TYPE2 = 8'h02;
    localparam logic [7:0]  KBC_MODE  = 8'h83;

    typedef enum logic [1:0] {
        KEY_LOCKED,
        KEY_HALF,
        KEY_OPEN
    } key_state_t;

    typedef struct packed {
        logic [7:0]  ldn;
        logic [15:0] base;
        logic [7:0]  irq;
        logic [7:0]  irq_type;
        logic        has_ext;
    } dev_cfg_t;

    // Returns the LDN and reset values of one device slot
    function automatic dev_cfg_t dev_cfg(input int slot);
        dev_cfg_t c;
        case (slot)
            0:       c = '{ldn: 8'h02, base: 16'h03F8, irq: 8'd4,  irq_type: 8'h02, has_ext: 1'b0};
            1:       c = '{ldn: 8'h03, base: 16'h02F8, irq: 8'd3,  irq_type: 8'h02, has_ext: 1'b0};
            2:       c = '{ldn: 8'h05, base: 16'h0060, irq: 8'd1,  irq_type: 8'h02, has_ext: 1'b1};
            3:       c = '{ldn: 8'h07, base: 16'h0000, irq: 8'h0B, irq_type: 8'h01, has_ext: 1'b0};
            4:       c = '{ldn: 8'h0B, base: 16'h03E8, irq: 8'd6,  irq_type: 8'h02, has_ext: 1'b0};
            5:       c = '{ldn: 8'h0C, base: 16'h02E8, irq: 8'd5,  irq_type: 8'h02, has_ext: 1'b0};
            default: c = '{ldn: 8'h0E, base: 16'h08C0, irq: 8'd9,  irq_type: 8'h01, has_ext: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sio_key_gate.sv
`timescale 1ns/1ps
// Module sio_key_gate
// Tracks the unlock key sequence on the index port and holds the current index.
// Assumes idx_wr is a single-cycle strobe for each index-port write.
// The index is stored only while the space is open and the byte is not the exit key.
module sio_key_gate
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       cfg_open,
    output logic [7:0] cfg_index
);

    key_state_t state_q;

    // Key sequence state machine and index register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= KEY_LOCKED;
            cfg_index <= 8'h00;
        end else if (idx_wr) begin
            case (state_q)
                KEY_LOCKED: if (wdata == KEY_ENTER) state_q <= KEY_HALF;
                KEY_HALF:   state_q <= (wdata == KEY_ENTER) ? KEY_OPEN : KEY_LOCKED;
                KEY_OPEN: begin
                    if (wdata == KEY_EXIT) state_q <= KEY_LOCKED;
                    else                   cfg_index <= wdata;
                end
                default:    state_q <= KEY_LOCKED;
            endcase
        end
    end

    // Open flag seen by the decode logic
    assign cfg_open = (state_q == KEY_OPEN);

endmodule

// File: rtl/sio_global_regs.sv
`timescale 1ns/1ps
// Module sio_global_regs
// Holds the LDN select register and the scratch area below index 0x30.
// Scratch entry 0 (index 0x20) is never written, so it reads as zero.
// Assumes wr_en is already qualified by an open space and a data-port write.
module sio_global_regs
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    output logic [7:0] ldn,
    output logic [7:0] rd_data,
    output logic       hit
);

    localparam int SLOT_W = $clog2(GLB_N);

    logic [7:0]        scr_q [GLB_N];
    logic              in_scr;
    logic [SLOT_W-1:0] slot;

    assign in_scr = (idx >= IDX_GLB_LO) && (idx < IDX_GLB_LO + 8'(GLB_N));
    assign slot   = idx[SLOT_W-1:0];

    // LDN select register
    always_ff @(posedge clk) begin
        if (!rst_n)                         ldn <= 8'h00;
        else if (wr_en && idx == IDX_LDN)   ldn <= wdata;
    end

    // Scratch registers; slot 0 stays read-only zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < GLB_N; i++) scr_q[i] <= 8'h00;
        end else if (wr_en && in_scr && slot != '0) begin
            scr_q[slot] <= wdata;
        end
    end

    // Read decode of the global area
    always_comb begin
        hit     = 1'b0;
        rd_data = RD_IDLE;
        if (idx == IDX_LDN) begin
            hit     = 1'b1;
            rd_data = ldn;
        end else if (in_scr) begin
            hit     = 1'b1;
            rd_data = scr_q[slot];
        end
    end

endmodule

// File: rtl/sio_dev_bank.sv
`timescale 1ns/1ps
// Module sio_dev_bank
// Register bank of one logical device, with its reset values taken from slot SLOT.
// Assumes wr_en is high only for open-space data writes at index 0x30 or above
// while the LDN selects this slot. Unimplemented indices clear hit.
module sio_dev_bank
    import sio_cfg_pkg::*;
#(
    parameter int SLOT  = 0,
    parameter int IRQ_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       rd_data,
    output logic             hit,
    output logic             active,
    output logic [15:0]      base,
    output logic [IRQ_W-1:0] irq
);

    localparam dev_cfg_t CFG = dev_cfg(SLOT);

    logic        act_q;
    logic [15:0] base_q, base2_q;
    logic [7:0]  irq_q, type_q, irq2_q, type2_q, mode_q;

    // Index decode and read mux
    always_comb begin
        hit     = 1'b1;
        rd_data = RD_IDLE;
        case (idx)
            8'h30: rd_data = {7'b0, act_q};
            8'h60: rd_data = base_q[15:8];
            8'h61: rd_data = base_q[7:0];
            8'h70: rd_data = irq_q;
            8'h71: rd_data = type_q;
            8'h62: if (CFG.has_ext) rd_data = base2_q[15:8]; else hit = 1'b0;
            8'h63: if (CFG.has_ext) rd_data = base2_q[7:0];  else hit = 1'b0;
            8'h72: if (CFG.has_ext) rd_data = irq2_q;        else hit = 1'b0;
            8'h73: if (CFG.has_ext) rd_data = type2_q;       else hit = 1'b0;
            8'hF0: if (CFG.has_ext) rd_data = mode_q;        else hit = 1'b0;
            default: hit = 1'b0;
        endcase
    end

    // Register update on decoded writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            base_q  <= CFG.base;
            irq_q   <= CFG.irq;
            type_q  <= CFG.irq_type;
            base2_q <= CFG.has_ext ? KBC_BASE2 : 16'h0000;
            irq2_q  <= CFG.has_ext ? KBC_IRQ2  : 8'h00;
            type2_q <= CFG.has_ext ? KBC_TYPE2 : 8'h00;
            mode_q  <= CFG.has_ext ? KBC_MODE  : 8'h00;
        end else if (wr_en && hit) begin
            case (idx)
                8'h30: act_q         <= wdata[0];
                8'h60: base_q[15:8]  <= wdata;
                8'h61: base_q[7:0]   <= wdata;
                8'h70: irq_q         <= wdata;
                8'h71: type_q        <= wdata;
                8'h62: base2_q[15:8] <= wdata;
                8'h63: base2_q[7:0]  <= wdata;
                8'h72: irq2_q        <= wdata;
                8'h73: type2_q       <= wdata;
                8'hF0: mode_q        <= wdata;
                default: ;
            endcase
        end
    end

    // Resource outputs for downstream decoders
    assign active = act_q;
    assign base   = base_q;
    assign irq    = irq_q[IRQ_W-1:0];

endmodule

// File: rtl/sio_cfg_space.sv
`timescale 1ns/1ps
// Module sio_cfg_space
// Top of the configuration space: key gate, global registers and one bank per device.
// Assumes one-cycle write strobes. Read data is combinational and valid while bus_rd is high.
module sio_cfg_space
    import sio_cfg_pkg::*;
#(
    parameter int IRQ_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    output logic [NDEV-1:0]       dev_active,
    output logic [NDEV*16-1:0]    dev_base,
    output logic [NDEV*IRQ_W-1:0] dev_irq
);

    logic       cfg_open;
    logic [7:0] cfg_index;
    logic [7:0] ldn;
    logic [7:0] glb_rd;
    logic       glb_hit;
    logic       data_wr;
    logic       in_bank;
    logic [NDEV-1:0] bank_sel, bank_hit;
    logic [7:0]      bank_rd [NDEV];

    assign data_wr = bus_wr && bus_addr && cfg_open;
    assign in_bank = (cfg_index >= IDX_BANK_LO);

    sio_key_gate i_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_wr    (bus_wr && !bus_addr),
        .wdata     (bus_wdata),
        .cfg_open  (cfg_open),
        .cfg_index (cfg_index)
    );

    sio_global_regs i_glb (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (data_wr && !in_bank),
        .idx     (cfg_index),
        .wdata   (bus_wdata),
        .ldn     (ldn),
        .rd_data (glb_rd),
        .hit     (glb_hit)
    );

    for (genvar g = 0; g < NDEV; g++) begin : g_bank
        localparam dev_cfg_t SCFG = dev_cfg(g);
        assign bank_sel[g] = (ldn == SCFG.ldn);
        sio_dev_bank #(.SLOT(g), .IRQ_W(IRQ_W)) i_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (data_wr && in_bank && bank_sel[g]),
            .idx     (cfg_index),
            .wdata   (bus_wdata),
            .rd_data (bank_rd[g]),
            .hit     (bank_hit[g]),
            .active  (dev_active[g]),
            .base    (dev_base[g*16 +: 16]),
            .irq     (dev_irq[g*IRQ_W +: IRQ_W])
        );
    end

    // Read data selection across ports, globals and the selected bank
    always_comb begin
        bus_rdata = RD_IDLE;
        if (bus_rd && cfg_open) begin
            if (!bus_addr) begin
                bus_rdata = cfg_index;
            end else if (!in_bank) begin
                if (glb_hit) bus_rdata = glb_rd;
            end else begin
                for (int i = 0; i < NDEV; i++)
                    if (bank_sel[i] && bank_hit[i]) bus_rdata = bank_rd[i];
            end
        end
    end

endmodule

// File: rtl/sio_cfg_space_chk.sv
`timescale 1ns/1ps
// Module sio_cfg_space_chk
// Property checker bound to sio_cfg_space; it observes ports and the key-gate state.
module sio_cfg_space_chk
    import sio_cfg_pkg::*;
#(
    parameter int IRQ_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_addr,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [7:0]            bus_wdata,
    input logic [7:0]            bus_rdata,
    input logic                  cfg_open,
    input logic [7:0]            cfg_index,
    input logic [NDEV-1:0]       dev_active,
    input logic [NDEV*16-1:0]    dev_base,
    input logic [NDEV*IRQ_W-1:0] dev_irq
);

    // R1: a locked space answers every read with all-ones
    p_locked_reads_ff_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !cfg_open) |-> (bus_rdata == RD_IDLE));

    // R2: opening is always preceded by an index write of the key byte
    p_open_after_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(bus_wr && !bus_addr && bus_wdata == KEY_ENTER));

    // R4: the exit key locks the space in the next cycle
    p_exit_locks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && bus_wr && !bus_addr && bus_wdata == KEY_EXIT) |=> !cfg_open);

    // R4: the exit key leaves the stored index unchanged
    p_exit_keeps_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && bus_wr && !bus_addr && bus_wdata == KEY_EXIT) |=> $stable(cfg_index));

    // R5: no device output moves after a locked cycle
    p_locked_outputs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> ($stable(dev_active) && $stable(dev_base) && $stable(dev_irq)));

    // R6: index 0x20 reads zero
    p_glb20_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr && cfg_open && cfg_index == 8'h20) |-> (bus_rdata == 8'h00));

    // R10: undecoded global indices read all-ones
    p_undecoded_ff_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr && cfg_open && cfg_index >= 8'h08 && cfg_index < 8'h20)
        |-> (bus_rdata == RD_IDLE));

    // R12: the index port returns the stored index while open
    p_index_readback_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_addr && cfg_open) |-> (bus_rdata == cfg_index));

endmodule

bind sio_cfg_space sio_cfg_space_chk #(.IRQ_W(IRQ_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .cfg_open   (cfg_open),
    .cfg_index  (cfg_index),
    .dev_active (dev_active),
    .dev_base   (dev_base),
    .dev_irq    (dev_irq)
);

// File: tb/test_sio_cfg_space.sv
`timescale 1ns/1ps
// Bench test_sio_cfg_space: directed scenarios, one task each, self-checking.
module test_sio_cfg_space;

    localparam int ND = 7;
    localparam int IW = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_addr = 1'b0;
    logic             bus_wr = 1'b0;
    logic             bus_rd = 1'b0;
    logic [7:0]       bus_wdata = 8'h00;
    logic [7:0]       bus_rdata;
    logic [ND-1:0]    dev_active;
    logic [ND*16-1:0] dev_base;
    logic [ND*IW-1:0] dev_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sio_cfg_space #(.IRQ_W(IW)) i_sio_cfg_space (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .dev_active (dev_active),
        .dev_base   (dev_base),
        .dev_irq    (dev_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bwr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        #0.5 bus_rd = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [7:0] v);
        bwr(1'b0, idx);
        bwr(1'b1, v);
    endtask

    task automatic reg_rd(input logic [7:0] idx, output logic [7:0] v);
        bwr(1'b0, idx);
        brd(1'b1, v);
    endtask

    task automatic unlock();
        bwr(1'b0, 8'hA5);
        bwr(1'b0, 8'hA5);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        brd(1'b0, v); check("R1 index port locked", v, 8'hFF);
        brd(1'b1, v); check("R1 data port locked", v, 8'hFF);
        check("R1 active after reset", dev_active, 0);
        check("R11 slot0 base reset", dev_base[0 +: 16], 16'h03F8);
        check("R11 slot0 irq reset", dev_irq[0 +: IW], 4);
    endtask

    task automatic t_unlock();
        logic [7:0] v;
        bwr(1'b0, 8'hA5);
        brd(1'b1, v); check("R2 one key still locked", v, 8'hFF);
        bwr(1'b0, 8'hA5);
        brd(1'b0, v); check("R12 index after unlock", v, 8'h00);
        reg_rd(8'h20, v); check("R6 index 0x20 zero", v, 8'h00);
    endtask

    task automatic t_abort();
        logic [7:0] v;
        bwr(1'b0, 8'hAA);
        bwr(1'b0, 8'hA5); bwr(1'b0, 8'h12); bwr(1'b0, 8'hA5);
        brd(1'b0, v); check("R3 broken sequence locked", v, 8'hFF);
        bwr(1'b0, 8'hA5);
        brd(1'b0, v); check("R3 R4 reopen keeps index", v, 8'h20);
    endtask

    task automatic t_scratch();
        logic [7:0] v;
        reg_rd(8'h25, v); check("R6 scratch reset", v, 8'h00);
        reg_wr(8'h21, 8'h5A); reg_wr(8'h2F, 8'hC3);
        reg_rd(8'h21, v); check("R6 scratch 0x21", v, 8'h5A);
        reg_rd(8'h2F, v); check("R6 scratch 0x2F", v, 8'hC3);
        reg_wr(8'h20, 8'h77);
        reg_rd(8'h20, v); check("R6 index 0x20 ignores write", v, 8'h00);
        reg_wr(8'h10, 8'h44);
        reg_rd(8'h10, v); check("R10 undecoded global", v, 8'hFF);
    endtask

    task automatic t_locked_write();
        logic [7:0] v;
        logic [ND*16-1:0] b;
        bwr(1'b0, 8'h21);
        bwr(1'b0, 8'hAA);
        bwr(1'b1, 8'h99);
        brd(1'b1, v); check("R1 data read after relock", v, 8'hFF);
        unlock();
        reg_rd(8'h21, v); check("R5 locked write ignored", v, 8'h5A);
        reg_wr(8'h07, 8'h02);
        bwr(1'b0, 8'h60);
        bwr(1'b0, 8'hAA);
        b = dev_base;
        bwr(1'b1, 8'h7E);
        @(negedge clk);
        check("R5 base output unchanged", dev_base, b);
        unlock();
        brd(1'b1, v); check("R5 base register unchanged", v, 8'h03);
    endtask

    task automatic chk_dev(input logic [7:0] ldn, input logic [15:0] base,
                           input logic [7:0] irq, input logic [7:0] typ);
        logic [7:0] v;
        reg_wr(8'h07, ldn);
        reg_rd(8'h07, v); check("R7 LDN readback", v, ldn);
        reg_rd(8'h60, v); check("R8 base high", v, base[15:8]);
        reg_rd(8'h61, v); check("R8 base low", v, base[7:0]);
        reg_rd(8'h70, v); check("R8 irq", v, irq);
        reg_rd(8'h71, v); check("R8 irq type", v, typ);
        reg_rd(8'h30, v); check("R8 activate", v, 8'h00);
    endtask

    task automatic t_defaults();
        logic [7:0] v;
        chk_dev(8'h02, 16'h03F8, 8'd4, 8'h02);
        chk_dev(8'h03, 16'h02F8, 8'd3, 8'h02);
        chk_dev(8'h0B, 16'h03E8, 8'd6, 8'h02);
        chk_dev(8'h0C, 16'h02E8, 8'd5, 8'h02);
        chk_dev(8'h0E, 16'h08C0, 8'd9, 8'h01);
        chk_dev(8'h07, 16'h0000, 8'h0B, 8'h01);
        chk_dev(8'h05, 16'h0060, 8'd1, 8'h02);
        reg_rd(8'h62, v); check("R9 kbc base2 high", v, 8'h00);
        reg_rd(8'h63, v); check("R9 kbc base2 low", v, 8'h64);
        reg_rd(8'h72, v); check("R9 kbc irq2", v, 8'h0C);
        reg_rd(8'h73, v); check("R9 kbc type2", v, 8'h02);
        reg_rd(8'hF0, v); check("R9 kbc mode", v, 8'h83);
    endtask

    task automatic t_unimpl();
        logic [7:0] v;
        reg_wr(8'h07, 8'h02);
        reg_wr(8'h62, 8'h11);
        reg_rd(8'h62, v); check("R10 missing bank index", v, 8'hFF);
        reg_wr(8'h07, 8'h04);
        reg_wr(8'h30, 8'h01);
        reg_rd(8'h30, v); check("R10 unknown LDN read", v, 8'hFF);
        @(negedge clk);
        check("R10 unknown LDN no activate", dev_active, 0);
    endtask

    task automatic t_outputs();
        reg_wr(8'h07, 8'h0B);
        reg_wr(8'h30, 8'h01);
        reg_wr(8'h60, 8'h12);
        reg_wr(8'h61, 8'h34);
        reg_wr(8'h70, 8'h0A);
        @(negedge clk);
        check("R11 active slot4", dev_active, 7'b0010000);
        check("R11 base slot4", dev_base[4*16 +: 16], 16'h1234);
        check("R11 irq slot4", dev_irq[4*IW +: IW], 4'hA);
        check("R7 slot5 untouched", dev_base[5*16 +: 16], 16'h02E8);
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        reg_wr(8'h21, 8'h11);
        @(negedge clk);
        bus_addr = 1'b1; bus_wdata = 8'h22; bus_wr = 1'b1; bus_rd = 1'b1;
        #1 v = bus_rdata;
        check("R13 read sees old value", v, 8'h11);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        brd(1'b1, v); check("R13 next read sees new value", v, 8'h22);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unlock();
        t_abort();
        t_scratch();
        t_locked_write();
        t_defaults();
        t_unimpl();
        t_outputs();
        t_same_cycle();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule